// File: doc/BRIEF.md
# Adaptive voltage code sequencer

This block sets a supply regulator to a part-specific voltage once, shortly after power-up. On a start request it takes the process code that sits in the low bits of a fuse-loaded parameter word and turns it into an 8-bit voltage ID with a fixed lookup. It then drives a byte-oriented I2C master through a single register write to the regulator. The write goes to device address 0x60 with the write bit, then register index 0x54, then the voltage ID.

The master on the other side takes level and pulse commands: enable, START, STOP, write byte, flag clears and interrupt-enable bits. It reports its progress on five status inputs. The sequencer recovers from a lost arbitration and from a missing acknowledge, and the recovery it uses depends on where the fault appeared. It retries the whole transaction a bounded number of times. It then ends either with a done pulse and a sticky done flag or with a sticky fatal flag.

Top module: `vcode_seq`

## Requirements
- R1: The voltage ID follows the lookup code 0x000→0x53, 0x001→0x52, 0x002→0x51, 0x004→0x50, 0x008→0x4F, 0x010→0x4E, 0x020→0x4D, 0x040→0x4C. The code is compared on bits [8:0] of the parameter word. The ID is latched on start and shown on `vid_o`.
- R2: A code that matches no entry, including one with bit 8 set, falls back to ID 0x53. Parameter bits above bit 8 are ignored.
- R3: A fault-free run does the following in order: it enables the master and issues START, and waits for data-empty. It then writes 0x60. After each later wait event it writes 0x54, then the ID, then issues STOP; with each of these it clears the wait flag. When busy drops it disables the master and gives one `done_pulse_o` cycle, and `done_o` then stays high. START, STOP and write are never issued in the same cycle.
- R4: Only a fresh rising edge of the wait or data-empty flag advances the sequence. A flag that stays high never advances two steps.
- R5: An arbitration loss seen while waiting for data-empty after START clears the arbitration flag and writes one dummy byte, 0x53, in the same cycle. At the next wait edge the block issues STOP and goes on to the error-end step.
- R6: An arbitration loss seen during any later byte clears the flag without writing a dummy byte. At the next wait edge the block issues STOP and goes on to the error-end step.
- R7: On a NACK the block issues STOP, clears the acknowledge flag and drops the wait enable (`m_ie_o` bit 1) and the data-empty enable (bit 0), all in the same cycle.
- R8: When arbitration loss and NACK are present together, the arbitration-loss path is taken and the acknowledge flag is not cleared.
- R9: In error-end the block waits for busy to drop, disables the master for at least one cycle and counts one retry. It then restarts from START with all three interrupt enables (`m_ie_o` = 3'b111) set again. One retry is allowed.
- R10: A fault seen when the retry already used ends in `fatal_o`. The flag stays high, the master is disabled, and `done_o` never rises.
- R11: After reset all outputs are low, `vid_o` is 0x00 and `m_ie_o` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go_i | input | 1 | Start request, taken only while idle |
| fuse_param_i | input | PARAM_W | Fuse-loaded parameter word; bits [8:0] are the code |
| st_wait_i | input | 1 | Master waits after a byte |
| st_dte_i | input | 1 | Master data register empty |
| st_busy_i | input | 1 | Bus busy |
| st_al_i | input | 1 | Arbitration lost |
| st_nack_i | input | 1 | No acknowledge received |
| m_enable_o | output | 1 | Master enable level |
| m_start_o | output | 1 | START command pulse |
| m_stop_o | output | 1 | STOP command pulse |
| m_wr_o | output | 1 | Write-byte pulse |
| m_wdata_o | output | 8 | Byte to write |
| m_clr_wait_o | output | 1 | Clear wait flag pulse |
| m_clr_al_o | output | 1 | Clear arbitration flag pulse |
| m_clr_nack_o | output | 1 | Clear acknowledge flag pulse |
| m_ie_o | output | 3 | Interrupt enables: bit0 data-empty, bit1 wait, bit2 NACK |
| vid_o | output | 8 | Voltage ID in use |
| done_pulse_o | output | 1 | One-cycle completion pulse |
| done_o | output | 1 | Sticky completion flag |
| fatal_o | output | 1 | Sticky fatal error flag |

## Verification
A bench model of the I2C master replies to commands with delayed status flags and can inject faults at a chosen byte and attempt. The lookup is tried with each single-bit code, with zero, with an unmatched value, with bit 8 set and with high garbage bits. These cases separate a correct compare from one that misses the fallback or looks at too many bits. Fault runs inject arbitration loss right after START, arbitration loss after a byte, NACK, both at once, and NACK on both attempts. The written byte log tells the dummy-byte path apart from the plain one, and the clear counts show which flag won. A run where the wait flag is never cleared tells edge-driven advance apart from level-driven advance.

// File: rtl/vcode_pkg.sv
// Shared types and constants for the adaptive voltage code sequencer.
// Assumes an 8-bit byte interface on the I2C master side.
package vcode_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_START,
        S_ADDR,
        S_REGIDX,
        S_DATA,
        S_STOP,
        S_END,
        S_DONE,
        S_AL_START,
        S_AL_XFER,
        S_NACK,
        S_ERR_STOP,
        S_ERR_END,
        S_FATAL
    } seq_state_e;

    localparam logic [7:0] SLV_WRITE_ADDR = 8'h60;
    localparam logic [7:0] VID_REG_IDX    = 8'h54;

    localparam int IE_DTE  = 0;
    localparam int IE_WAIT = 1;
    localparam int IE_NACK = 2;
    localparam int IE_W    = 3;

endpackage

// File: rtl/vcode_lut.sv
// Process code to voltage ID lookup.
// Entry 0 has code zero; entry i>0 has code with only bit i-1 set.
// Entry i maps to VID_TOP - i. Unmatched codes return VID_TOP.
// Assumes N_ENT-1 <= CODE_W so every entry code fits.
module vcode_lut #(
    parameter int         CODE_W  = 9,
    parameter int         N_ENT   = 8,
    parameter logic [7:0] VID_TOP = 8'h53
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [7:0]        vid_o
);

    logic [N_ENT-1:0] hit;
    logic [7:0]       ent_vid [N_ENT];

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        localparam logic [CODE_W-1:0] KEY = CODE_W'((1 << i) >> 1);
        assign hit[i]     = (code_i == KEY);
        assign ent_vid[i] = 8'(VID_TOP - 8'(i));
    end

    // Select the matching entry's ID, default to the top entry.
    always_comb begin
        vid_o = VID_TOP;
        for (int i = 0; i < N_ENT; i++) begin
            if (hit[i]) vid_o = ent_vid[i];
        end
    end

endmodule

// File: rtl/vcode_rise.sv
// Rising edge detector for a set of status flags.
// Assumes flags are synchronous to clk.
module vcode_rise #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] flag_q;

    // Remember last cycle's flag levels.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_i;
    end

    assign rise_o = flag_i & ~flag_q;

endmodule

// File: rtl/vcode_fsm.sv
// Write-and-recover state machine for the voltage sequencer.
// Issues the register write over the master command interface.
// Recovers from arbitration loss and NACK, with MAX_RETRY retries.
// Assumes progress flags arrive as single-cycle rise pulses and
// that fault flags are levels cleared through the clear commands.
module vcode_fsm
    import vcode_pkg::*;
#(
    parameter int         MAX_RETRY = 1,
    parameter logic [7:0] DEF_VID   = 8'h53
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go_i,
    input  logic [7:0]      lut_vid_i,
    input  logic            dte_rise_i,
    input  logic            wait_rise_i,
    input  logic            busy_i,
    input  logic            al_i,
    input  logic            nack_i,
    output logic            enable_o,
    output logic            start_o,
    output logic            stop_o,
    output logic            wr_o,
    output logic [7:0]      wdata_o,
    output logic            clr_wait_o,
    output logic            clr_al_o,
    output logic            clr_nack_o,
    output logic [IE_W-1:0] ie_o,
    output logic [7:0]      vid_o,
    output logic            done_pulse_o,
    output logic            done_o,
    output logic            fatal_o
);

    localparam int RW = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);

    seq_state_e      state_q;
    seq_state_e      fault_tgt;
    logic [RW-1:0]   retry_q;
    logic            in_xfer;
    logic            fault;
    logic            exhausted;

    // Decode fault presence and the recovery target for this state.
    always_comb begin
        in_xfer   = (state_q == S_ADDR) || (state_q == S_REGIDX) ||
                    (state_q == S_DATA) || (state_q == S_STOP);
        fault     = in_xfer && (al_i || nack_i);
        exhausted = (retry_q >= RW'(MAX_RETRY));
        if (al_i) fault_tgt = (state_q == S_ADDR) ? S_AL_START : S_AL_XFER;
        else      fault_tgt = S_NACK;
    end

    // Sequence state, commands and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            retry_q      <= '0;
            enable_o     <= 1'b0;
            start_o      <= 1'b0;
            stop_o       <= 1'b0;
            wr_o         <= 1'b0;
            wdata_o      <= 8'h00;
            clr_wait_o   <= 1'b0;
            clr_al_o     <= 1'b0;
            clr_nack_o   <= 1'b0;
            ie_o         <= '0;
            vid_o        <= 8'h00;
            done_pulse_o <= 1'b0;
            done_o       <= 1'b0;
            fatal_o      <= 1'b0;
        end else begin
            start_o      <= 1'b0;
            stop_o       <= 1'b0;
            wr_o         <= 1'b0;
            clr_wait_o   <= 1'b0;
            clr_al_o     <= 1'b0;
            clr_nack_o   <= 1'b0;
            done_pulse_o <= 1'b0;
            if (fault) begin
                if (exhausted) begin
                    state_q  <= S_FATAL;
                    fatal_o  <= 1'b1;
                    enable_o <= 1'b0;
                end else begin
                    state_q  <= fault_tgt;
                end
            end else begin
                unique case (state_q)
                    S_IDLE: begin
                        if (go_i) begin
                            vid_o   <= lut_vid_i;
                            state_q <= S_START;
                        end
                    end
                    S_START: begin
                        enable_o <= 1'b1;
                        ie_o     <= '1;
                        start_o  <= 1'b1;
                        state_q  <= S_ADDR;
                    end
                    S_ADDR: begin
                        if (dte_rise_i) begin
                            ie_o[IE_DTE] <= 1'b0;
                            wr_o         <= 1'b1;
                            wdata_o      <= SLV_WRITE_ADDR;
                            state_q      <= S_REGIDX;
                        end
                    end
                    S_REGIDX: begin
                        if (wait_rise_i) begin
                            wr_o       <= 1'b1;
                            wdata_o    <= VID_REG_IDX;
                            clr_wait_o <= 1'b1;
                            state_q    <= S_DATA;
                        end
                    end
                    S_DATA: begin
                        if (wait_rise_i) begin
                            wr_o       <= 1'b1;
                            wdata_o    <= vid_o;
                            clr_wait_o <= 1'b1;
                            state_q    <= S_STOP;
                        end
                    end
                    S_STOP: begin
                        if (wait_rise_i) begin
                            stop_o     <= 1'b1;
                            clr_wait_o <= 1'b1;
                            state_q    <= S_END;
                        end
                    end
                    S_END: begin
                        if (!busy_i) begin
                            enable_o     <= 1'b0;
                            done_pulse_o <= 1'b1;
                            done_o       <= 1'b1;
                            state_q      <= S_DONE;
                        end
                    end
                    S_AL_START: begin
                        clr_al_o <= 1'b1;
                        wr_o     <= 1'b1;
                        wdata_o  <= DEF_VID;
                        state_q  <= S_ERR_STOP;
                    end
                    S_AL_XFER: begin
                        clr_al_o <= 1'b1;
                        state_q  <= S_ERR_STOP;
                    end
                    S_NACK: begin
                        stop_o        <= 1'b1;
                        ie_o[IE_WAIT] <= 1'b0;
                        ie_o[IE_DTE]  <= 1'b0;
                        clr_nack_o    <= 1'b1;
                        state_q       <= S_ERR_END;
                    end
                    S_ERR_STOP: begin
                        if (wait_rise_i) begin
                            stop_o     <= 1'b1;
                            clr_wait_o <= 1'b1;
                            state_q    <= S_ERR_END;
                        end
                    end
                    S_ERR_END: begin
                        if (!busy_i) begin
                            enable_o <= 1'b0;
                            retry_q  <= retry_q + 1'b1;
                            state_q  <= S_START;
                        end
                    end
                    S_DONE:  state_q <= S_DONE;
                    S_FATAL: state_q <= S_FATAL;
                    default: state_q <= S_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/vcode_seq.sv
// Top of the adaptive voltage code sequencer.
// Looks up the voltage ID from the fuse code and writes it to the
// regulator through a byte-oriented I2C master command interface.
// Assumes all status inputs are synchronous to clk.
module vcode_seq #(
    parameter int         PARAM_W   = 32,
    parameter int         CODE_W    = 9,
    parameter int         N_ENT     = 8,
    parameter logic [7:0] VID_TOP   = 8'h53,
    parameter int         MAX_RETRY = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [PARAM_W-1:0] fuse_param_i,
    input  logic               st_wait_i,
    input  logic               st_dte_i,
    input  logic               st_busy_i,
    input  logic               st_al_i,
    input  logic               st_nack_i,
    output logic               m_enable_o,
    output logic               m_start_o,
    output logic               m_stop_o,
    output logic               m_wr_o,
    output logic [7:0]         m_wdata_o,
    output logic               m_clr_wait_o,
    output logic               m_clr_al_o,
    output logic               m_clr_nack_o,
    output logic [2:0]         m_ie_o,
    output logic [7:0]         vid_o,
    output logic               done_pulse_o,
    output logic               done_o,
    output logic               fatal_o
);

    logic [7:0] lut_vid;
    logic [1:0] rise;
    logic       unused_hi;

    assign unused_hi = ^fuse_param_i[PARAM_W-1:CODE_W];

    vcode_lut #(
        .CODE_W  (CODE_W),
        .N_ENT   (N_ENT),
        .VID_TOP (VID_TOP)
    ) u_lut (
        .code_i (fuse_param_i[CODE_W-1:0]),
        .vid_o  (lut_vid)
    );

    vcode_rise #(
        .N (2)
    ) u_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .flag_i ({st_wait_i, st_dte_i}),
        .rise_o (rise)
    );

    vcode_fsm #(
        .MAX_RETRY (MAX_RETRY),
        .DEF_VID   (VID_TOP)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (go_i),
        .lut_vid_i    (lut_vid),
        .dte_rise_i   (rise[0]),
        .wait_rise_i  (rise[1]),
        .busy_i       (st_busy_i),
        .al_i         (st_al_i),
        .nack_i       (st_nack_i),
        .enable_o     (m_enable_o),
        .start_o      (m_start_o),
        .stop_o       (m_stop_o),
        .wr_o         (m_wr_o),
        .wdata_o      (m_wdata_o),
        .clr_wait_o   (m_clr_wait_o),
        .clr_al_o     (m_clr_al_o),
        .clr_nack_o   (m_clr_nack_o),
        .ie_o         (m_ie_o),
        .vid_o        (vid_o),
        .done_pulse_o (done_pulse_o),
        .done_o       (done_o),
        .fatal_o      (fatal_o)
    );

endmodule

// File: rtl/vcode_seq_checker.sv
// Property checker for vcode_seq, attached by bind below.
// Assumes the master command outputs are registered.
module vcode_seq_checker #(
    parameter logic [7:0] DEF_VID = 8'h53
) (
    input logic       clk,
    input logic       rst_n,
    input logic       st_busy_i,
    input logic       m_enable_o,
    input logic       m_start_o,
    input logic       m_stop_o,
    input logic       m_wr_o,
    input logic [7:0] m_wdata_o,
    input logic       m_clr_al_o,
    input logic       m_clr_nack_o,
    input logic [2:0] m_ie_o,
    input logic       done_pulse_o,
    input logic       done_o,
    input logic       fatal_o
);

    p_cmd_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({m_start_o, m_stop_o, m_wr_o}));

    p_start_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m_start_o |-> m_enable_o);

    p_done_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse_o |=> !done_pulse_o);

    p_done_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o);

    p_done_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> !$past(st_busy_i));

    p_dummy_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wr_o && m_clr_al_o) |-> (m_wdata_o == DEF_VID));

    p_nack_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        m_clr_nack_o |-> (m_ie_o[1:0] == 2'b00 && m_stop_o));

    p_rearm_r9: assert property (@(posedge clk) disable iff (!rst_n)
        m_start_o |-> (m_ie_o == 3'b111));

    p_fatal_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        fatal_o |=> (fatal_o && !m_enable_o));

    p_excl_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fatal_o));

endmodule

bind vcode_seq vcode_seq_checker #(.DEF_VID(VID_TOP)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .st_busy_i    (st_busy_i),
    .m_enable_o   (m_enable_o),
    .m_start_o    (m_start_o),
    .m_stop_o     (m_stop_o),
    .m_wr_o       (m_wr_o),
    .m_wdata_o    (m_wdata_o),
    .m_clr_al_o   (m_clr_al_o),
    .m_clr_nack_o (m_clr_nack_o),
    .m_ie_o       (m_ie_o),
    .done_pulse_o (done_pulse_o),
    .done_o       (done_o),
    .fatal_o      (fatal_o)
);

// File: tb/vcode_seq_tb.sv
`timescale 1ns/1ps
// Directed bench for vcode_seq with a reactive I2C master model.
module vcode_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go_i = 1'b0;
    logic [31:0] fuse_param_i = '0;
    logic        st_wait_i = 1'b0, st_dte_i = 1'b0, st_busy_i = 1'b0;
    logic        st_al_i = 1'b0, st_nack_i = 1'b0;
    logic        m_enable_o, m_start_o, m_stop_o, m_wr_o;
    logic [7:0]  m_wdata_o;
    logic        m_clr_wait_o, m_clr_al_o, m_clr_nack_o;
    logic [2:0]  m_ie_o;
    logic [7:0]  vid_o;
    logic        done_pulse_o, done_o, fatal_o;

    int checks = 0;
    int errors = 0;

    // Master model bookkeeping
    int n_start, n_stop, n_wr, n_clr_al, n_clr_nack, n_en_fall, n_done_p, n_viol;
    int cur_byte;
    int dte_t, wait_t, al_t, nk_t, busy_t;
    logic [7:0] wlog [0:15];
    logic [2:0] ie_at_nack;
    logic       en_prev;
    // Injection: 0 none, 1 AL after START, 2 AL on byte, 3 NACK on byte, 4 both
    int   inj_kind, inj_byte;
    bit   inj_all, stuck;

    always #2 clk = ~clk;

    vcode_seq u_dut (
        .clk(clk), .rst_n(rst_n), .go_i(go_i), .fuse_param_i(fuse_param_i),
        .st_wait_i(st_wait_i), .st_dte_i(st_dte_i), .st_busy_i(st_busy_i),
        .st_al_i(st_al_i), .st_nack_i(st_nack_i),
        .m_enable_o(m_enable_o), .m_start_o(m_start_o), .m_stop_o(m_stop_o),
        .m_wr_o(m_wr_o), .m_wdata_o(m_wdata_o), .m_clr_wait_o(m_clr_wait_o),
        .m_clr_al_o(m_clr_al_o), .m_clr_nack_o(m_clr_nack_o), .m_ie_o(m_ie_o),
        .vid_o(vid_o), .done_pulse_o(done_pulse_o), .done_o(done_o), .fatal_o(fatal_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        check(act == exp, tag, act, exp);
    endtask

    // One step of the master model, run at each falling edge.
    task model_step();
        bit applies;
        if (!rst_n) begin
            {st_wait_i, st_dte_i, st_busy_i, st_al_i, st_nack_i} = '0;
            {dte_t, wait_t, al_t, nk_t, busy_t} = '0;
            en_prev = 1'b0;
            return;
        end
        if (dte_t > 0) begin dte_t--; if (dte_t == 0) st_dte_i = 1'b1; end
        if (wait_t > 0) begin wait_t--; if (wait_t == 0) st_wait_i = 1'b1; end
        if (al_t > 0) begin al_t--; if (al_t == 0) st_al_i = 1'b1; end
        if (nk_t > 0) begin nk_t--; if (nk_t == 0) st_nack_i = 1'b1; end
        if (busy_t > 0) begin busy_t--; if (busy_t == 0) st_busy_i = 1'b0; end
        if (en_prev && !m_enable_o) n_en_fall++;
        en_prev = m_enable_o;
        if (done_pulse_o) n_done_p++;
        if (st_busy_i && done_o) n_viol++;
        if (m_start_o) begin
            n_start++;
            {st_al_i, st_nack_i, st_dte_i, st_wait_i} = '0;
            st_busy_i = 1'b1;
            busy_t = 0;
            cur_byte = 0;
            applies = inj_all || (n_start == 1);
            if (applies && inj_kind == 1) al_t = 3;
            else dte_t = 3;
        end
        if (m_wr_o) begin
            applies = inj_all || (n_start == 1);
            if (n_wr < 16) wlog[n_wr] = m_wdata_o;
            n_wr++;
            st_dte_i = 1'b0;
            if (!stuck) st_wait_i = 1'b0;
            if (applies && inj_kind >= 2 && cur_byte == inj_byte) begin
                if (inj_kind != 3) al_t = 4;
                if (inj_kind != 2) nk_t = 4;
            end else begin
                wait_t = 4;
            end
            cur_byte++;
        end
        if (m_clr_wait_o && !stuck) st_wait_i = 1'b0;
        if (m_clr_al_o) begin
            n_clr_al++;
            st_al_i = 1'b0;
            if (!m_wr_o) wait_t = 5;
        end
        if (m_clr_nack_o) begin
            n_clr_nack++;
            st_nack_i = 1'b0;
            ie_at_nack = m_ie_o;
        end
        if (m_stop_o) begin
            n_stop++;
            busy_t = 6;
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            model_step();
        end
    end

    task automatic do_reset(input int kind, input int byte_ix, input bit all, input bit stk);
        @(negedge clk);
        rst_n = 1'b0;
        go_i = 1'b0;
        inj_kind = kind; inj_byte = byte_ix; inj_all = all; stuck = stk;
        {n_start, n_stop, n_wr, n_clr_al, n_clr_nack, n_en_fall, n_done_p, n_viol} = '0;
        cur_byte = 0;
        ie_at_nack = '1;
        for (int i = 0; i < 16; i++) wlog[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic run(input logic [31:0] param, input int max_cyc);
        fuse_param_i = param;
        @(negedge clk);
        go_i = 1'b1;
        @(negedge clk);
        go_i = 1'b0;
        for (int i = 0; i < max_cyc; i++) begin
            @(posedge clk); #1;
            if (done_o || fatal_o) break;
        end
        repeat (4) @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        do_reset(0, 0, 0, 0);
        @(posedge clk); #1;
        chk_eq("R11 outputs low", {m_enable_o, m_start_o, m_stop_o, m_wr_o, m_clr_wait_o,
               m_clr_al_o, m_clr_nack_o, done_pulse_o, done_o, fatal_o}, 0);
        chk_eq("R11 vid", vid_o, 8'h00);
        chk_eq("R11 ie", m_ie_o, 3'b000);
    endtask

    task automatic t_normal(input logic [31:0] param, input logic [7:0] exp, input string tag);
        do_reset(0, 0, 0, 0);
        run(param, 500);
        chk_eq({tag, " vid"}, vid_o, exp);
        chk_eq("R3 byte count", n_wr, 3);
        chk_eq("R3 byte0 addr", wlog[0], 8'h60);
        chk_eq("R3 byte1 index", wlog[1], 8'h54);
        chk_eq({tag, " byte2 id"}, wlog[2], exp);
        chk_eq("R3 start/stop", n_start * 16 + n_stop, 16 + 1);
        chk_eq("R3 done sticky", done_o, 1);
        chk_eq("R3 one done pulse", n_done_p, 1);
        chk_eq("R3 master off", m_enable_o, 0);
        chk_eq("R3 done after bus idle", n_viol, 0);
    endtask

    task automatic t_al_start();
        do_reset(1, 0, 0, 0);
        run(32'h004, 1000);
        chk_eq("R5 dummy first byte", wlog[0], 8'h53);
        chk_eq("R5 byte count", n_wr, 4);
        chk_eq("R5 retry addr", wlog[1], 8'h60);
        chk_eq("R5 retry id", wlog[3], 8'h50);
        chk_eq("R5 al cleared once", n_clr_al, 1);
        chk_eq("R9 two starts two stops", n_start * 16 + n_stop, 2 * 16 + 2);
        chk_eq("R9 master off between", n_en_fall, 2);
        chk_eq("R9 done after retry", done_o, 1);
    endtask

    task automatic t_al_xfer();
        do_reset(2, 0, 0, 0);
        run(32'h020, 1000);
        chk_eq("R6 no dummy, first byte addr", wlog[0], 8'h60);
        chk_eq("R6 byte count", n_wr, 4);
        chk_eq("R6 retry id", wlog[3], 8'h4D);
        chk_eq("R6 al cleared once", n_clr_al, 1);
        chk_eq("R6 done", done_o, 1);
    endtask

    task automatic t_nack();
        do_reset(3, 2, 0, 0);
        run(32'h001, 1000);
        chk_eq("R7 nack cleared once", n_clr_nack, 1);
        chk_eq("R7 wait/dte enables masked", ie_at_nack[1:0], 0);
        chk_eq("R7 stops", n_stop, 2);
        chk_eq("R7 byte count", n_wr, 6);
        chk_eq("R9 retry id", wlog[5], 8'h52);
        chk_eq("R9 done", done_o, 1);
    endtask

    task automatic t_both();
        do_reset(4, 1, 0, 0);
        run(32'h008, 1000);
        chk_eq("R8 al path taken", n_clr_al, 1);
        chk_eq("R8 nack not cleared", n_clr_nack, 0);
        chk_eq("R8 byte count", n_wr, 5);
        chk_eq("R8 done", done_o, 1);
    endtask

    task automatic t_fatal();
        do_reset(3, 0, 1, 0);
        run(32'h002, 1000);
        chk_eq("R10 fatal", fatal_o, 1);
        chk_eq("R10 no done", done_o, 0);
        chk_eq("R10 no done pulse", n_done_p, 0);
        chk_eq("R10 master off", m_enable_o, 0);
        chk_eq("R10 two attempts", n_start, 2);
    endtask

    task automatic t_stuck();
        do_reset(0, 0, 0, 1);
        run(32'h010, 200);
        chk_eq("R4 held wait gives one step", n_wr, 2);
        chk_eq("R4 no done", done_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_normal(32'h010, 8'h4E, "R1 code 0x010");
        t_normal(32'h000, 8'h53, "R1 code 0x000");
        t_normal(32'h040, 8'h4C, "R1 code 0x040");
        t_normal(32'h003, 8'h53, "R2 unmatched");
        t_normal(32'h100, 8'h53, "R2 bit8 set");
        t_normal(32'hFFFF_FE08, 8'h4F, "R2 high bits ignored");
        t_al_start();
        t_al_xfer();
        t_nack();
        t_both();
        t_fatal();
        t_stuck();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule